// File: doc/BRIEF.md
# Counting Frequency-Locked Supply Controller

This block closes a digital frequency-locked loop around a supply DAC. A ring oscillator built as a copy of the logic block's critical path runs from the controlled supply. The block counts that oscillator's rising edges, after an optional divide-by-N prescaler, over a window measured in reference-clock cycles. At the end of each window it compares the count against an expected count. It then moves the supply code by one LSB: up when the replica is too slow, down when it is too fast. Nothing else is adjusted, and the threshold setting is not touched.

The update rate is one decision per window, so the window should be kept short. This lets the loop track faster than any slower optimisation loop sharing the block. Count errors inside a programmable deadband cause no step. The code never leaves the programmed minimum and maximum limits. A lock flag rises once the loop has stopped making repeated steps in one direction for a programmable number of windows. At lock the code rests at the ideal value or moves back and forth by one LSB around it.

Top module: `supply_fll`

## Requirements
- R1: While `rst_ni` is low, `code_o` equals the parameter `INIT_CODE` (default 128) and `lock_o` is 0.
- R2: While `en_i` is low, `code_o` holds its value, `lock_o` is 0, and the window counter, prescaler and settle history are cleared. The first window starts on the first clock edge at which `en_i` is sampled high.
- R3: `osc_i` passes through a two-flop synchronizer. Each of its rising edges is counted exactly once. A window lasts `win_len_i` reference cycles (0 is treated as 1), and a periodic input whose period divides the window gives the exact quotient per window.
- R4: The prescaler divides the counted edges by `div_n_i` (0 is treated as 1). With `div_n_i`=2, 16 edges per window give a count of 8.
- R5: If count + `deadband_i` < `tgt_cnt_i` at a window end, `code_o` rises by 1 on that window's last clock edge.
- R6: If count > `tgt_cnt_i` + `deadband_i` at a window end, `code_o` falls by 1 on that window's last clock edge.
- R7: If count lies within `tgt_cnt_i` ± `deadband_i`, both bounds included, the code holds. With `deadband_i`=0 only an exact match holds.
- R8: An up step is dropped when `code_o` >= `code_max_i`, so the code never rises above the maximum.
- R9: A down step is dropped when `code_o` <= `code_min_i`, so the code never falls below the minimum.
- R10: `code_o` changes by at most one LSB per clock edge.
- R11: A window is "settled" when it requests no step, or requests a step opposite to the most recent nonzero request. A settled window counts up a settle counter; any other window clears it. `lock_o` is 1 while the counter is >= `lock_len_i` (0 treated as 1), so it changes only right after a window end.
- R12: In closed loop, with replica frequency rising with the code, the loop reaches lock with the code near the ideal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Loop enable |
| osc_i | input | 1 | Replica oscillator, asynchronous |
| div_n_i | input | 8 | Prescaler ratio N |
| win_len_i | input | 16 | Window length in reference cycles |
| tgt_cnt_i | input | 16 | Expected count per window |
| deadband_i | input | 4 | Allowed count error without a step |
| code_min_i | input | 8 | Lowest permitted code |
| code_max_i | input | 8 | Highest permitted code |
| lock_len_i | input | 6 | Settled windows needed for lock |
| code_o | output | 8 | Supply DAC code |
| lock_o | output | 1 | Lock indicator |

## Verification
The open-loop patterns use a replica driven with periods of 2 and 4 reference cycles against a 64-cycle window. This makes the count exact: 32 or 16 edges, or 8 through the divide-by-2 prescaler. Targets are then placed below, on and just outside the deadband bounds. These cases separate an off-by-one in the count or the comparison from a correct deadband, and show that an up step and a down step are taken in the right direction. Running into each limit with repeated requests shows that saturation drops a step rather than wrapping or clamping. It also shows that blocked same-direction requests clear lock. A final closed-loop run lets the replica frequency follow the code, which shows that the loop converges and declares lock.

// File: rtl/supply_fll_pkg.sv
package supply_fll_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/sfll_edge_sync.sv
module sfll_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/sfll_win_counter.sv
module sfll_win_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned WIN_W = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic [DIV_W-1:0] div_n_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [DIV_W-1:0] pre_q, div_eff;
  logic [DIV_W:0]   pre_nx;
  logic [WIN_W-1:0] wcnt_q, win_eff, win_last;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign div_eff  = (div_n_i == '0) ? DIV_W'(1) : div_n_i;
  assign pre_nx   = {1'b0, pre_q} + (DIV_W+1)'(1);
  assign tick     = en_i & rise_i & (pre_nx >= {1'b0, div_eff});

  assign win_eff  = (win_len_i == '0) ? WIN_W'(1) : win_len_i;
  assign win_last = win_eff - WIN_W'(1);
  assign done_o   = en_i & (wcnt_q >= win_last);

  // final count includes the tick landing on the last cycle
  assign cnt_o = (tick && cnt_q != '1) ? cnt_q + CNT_W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (!en_i) begin
      pre_q <= '0;
    end else if (rise_i) begin
      pre_q <= tick ? '0 : pre_nx[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      cnt_q  <= '0;
    end else if (!en_i || done_o) begin
      wcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      wcnt_q <= wcnt_q + WIN_W'(1);
      cnt_q  <= cnt_o;
    end
  end
endmodule

// File: rtl/sfll_step_ctrl.sv
module sfll_step_ctrl
  import supply_fll_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned DB_W      = 4,
  parameter int unsigned INIT_CODE = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  tgt_i,
  input  logic [DB_W-1:0]   db_i,
  input  logic [CODE_W-1:0] min_i,
  input  logic [CODE_W-1:0] max_i,
  output step_e             dir_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned EW = CNT_W + 1;

  logic [EW-1:0]     cnt_x, tgt_x, db_x;
  logic [CODE_W-1:0] code_q, code_d;

  assign cnt_x = {1'b0, cnt_i};
  assign tgt_x = {1'b0, tgt_i};
  assign db_x  = EW'(db_i);

  always_comb begin
    if (cnt_x + db_x < tgt_x)      dir_o = STEP_UP;
    else if (cnt_x > tgt_x + db_x) dir_o = STEP_DN;
    else                           dir_o = STEP_NONE;
  end

  // a step at or beyond a limit is dropped, never clamped
  always_comb begin
    code_d = code_q;
    if (done_i) begin
      if (dir_o == STEP_UP && code_q < max_i)      code_d = code_q + CODE_W'(1);
      else if (dir_o == STEP_DN && code_q > min_i) code_d = code_q - CODE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_W'(INIT_CODE);
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/sfll_lock_det.sv
module sfll_lock_det
  import supply_fll_pkg::*;
#(
  parameter int unsigned LOCK_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  step_e             dir_i,
  input  logic [LOCK_W-1:0] lock_len_i,
  output logic              lock_o
);
  logic [LOCK_W-1:0] settle_q, need;
  step_e             last_q;
  logic              settled;

  assign settled = (dir_i == STEP_NONE) || (dir_i != last_q);
  assign need    = (lock_len_i == '0) ? LOCK_W'(1) : lock_len_i;
  assign lock_o  = (settle_q >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
      last_q   <= STEP_NONE;
    end else if (!en_i) begin
      settle_q <= '0;
      last_q   <= STEP_NONE;
    end else if (done_i) begin
      if (!settled)             settle_q <= '0;
      else if (settle_q != '1)  settle_q <= settle_q + LOCK_W'(1);
      if (dir_i != STEP_NONE)   last_q <= dir_i;
    end
  end
endmodule

// File: rtl/supply_fll.sv
module supply_fll
  import supply_fll_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned WIN_W     = 16,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DB_W      = 4,
  parameter int unsigned LOCK_W    = 6,
  parameter int unsigned INIT_CODE = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              osc_i,
  input  logic [DIV_W-1:0]  div_n_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [CNT_W-1:0]  tgt_cnt_i,
  input  logic [DB_W-1:0]   deadband_i,
  input  logic [CODE_W-1:0] code_min_i,
  input  logic [CODE_W-1:0] code_max_i,
  input  logic [LOCK_W-1:0] lock_len_i,
  output logic [CODE_W-1:0] code_o,
  output logic              lock_o
);
  logic             osc_rise, win_done;
  logic [CNT_W-1:0] win_cnt;
  step_e            step_dir;

  sfll_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(osc_i),
    .rise_o (osc_rise)
  );

  sfll_win_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W), .DIV_W(DIV_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .rise_i   (osc_rise),
    .div_n_i  (div_n_i),
    .win_len_i(win_len_i),
    .done_o   (win_done),
    .cnt_o    (win_cnt)
  );

  sfll_step_ctrl #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .DB_W(DB_W), .INIT_CODE(INIT_CODE)
  ) u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(win_done),
    .cnt_i (win_cnt),
    .tgt_i (tgt_cnt_i),
    .db_i  (deadband_i),
    .min_i (code_min_i),
    .max_i (code_max_i),
    .dir_o (step_dir),
    .code_o(code_o)
  );

  sfll_lock_det #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .done_i    (win_done),
    .dir_i     (step_dir),
    .lock_len_i(lock_len_i),
    .lock_o    (lock_o)
  );
endmodule

// File: rtl/sfll_chk.sv
module sfll_chk
  import supply_fll_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              done_i,
  input step_e             dir_i,
  input logic [CODE_W-1:0] code_i,
  input logic [CODE_W-1:0] min_i,
  input logic [CODE_W-1:0] max_i,
  input logic              lock_i
);
  // R10
  one_lsb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != $past(code_i)) |->
      ((code_i == $past(code_i) + CODE_W'(1)) || (code_i == $past(code_i) - CODE_W'(1))));

  // R2
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(code_i) && !lock_i));

  // R5
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dir_i == STEP_UP && code_i < max_i) |=> (code_i == $past(code_i) + CODE_W'(1)));

  // R6
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dir_i == STEP_DN && code_i > min_i) |=> (code_i == $past(code_i) - CODE_W'(1)));

  // R8
  max_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i > $past(code_i)) |-> (code_i <= max_i));

  // R9
  min_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i < $past(code_i)) |-> (code_i >= min_i));

  // R11
  lock_at_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i) |-> $past(done_i));
endmodule

bind supply_fll sfll_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .done_i(win_done),
  .dir_i (step_dir),
  .code_i(code_o),
  .min_i (code_min_i),
  .max_i (code_max_i),
  .lock_i(lock_o)
);

// File: tb/sim_supply_fll.sv
`timescale 1ns/1ps
module sim_supply_fll;
  localparam int W = 64;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic       osc_ol = 1'b0, osc_cl = 1'b0, cl_mode = 1'b0;
  logic       osc;
  logic [7:0] code;
  logic       lock;

  int tgt = 16, db = 1, cmin = 100, cmax = 131, llen = 3, div = 1, half = 2;
  int m_code = 128, m_settle = 0, m_last = 0;
  int total = 0, bad = 0, ph = 0;

  typedef struct { int code; int lock; string tag; } exp_t;
  exp_t q[$];
  event mon_ev;

  always #2.5 clk = ~clk;

  assign osc = cl_mode ? osc_cl : osc_ol;

  supply_fll u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .osc_i(osc),
    .div_n_i(8'(div)), .win_len_i(16'(W)), .tgt_cnt_i(16'(tgt)),
    .deadband_i(4'(db)), .code_min_i(8'(cmin)), .code_max_i(8'(cmax)),
    .lock_len_i(6'(llen)), .code_o(code), .lock_o(lock)
  );

  // open-loop replica: period 2*half reference cycles
  always @(negedge clk) begin
    if (!cl_mode) begin
      if (ph >= half - 1) begin osc_ol <= ~osc_ol; ph <= 0; end
      else ph <= ph + 1;
    end
  end

  // closed-loop replica: frequency proportional to code
  always begin
    if (cl_mode) #(2000.0 / real'((code == 0) ? 1 : code)) osc_cl = ~osc_cl;
    else @(cl_mode);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: pops expectations as windows complete
  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      e = q.pop_front();
      chk(code == 8'(e.code), {e.tag, " code"}, code, e.code);
      chk(lock == 1'(e.lock), {e.tag, " lock"}, lock, e.lock);
    end
  end

  // driver: predicts the window result, queues it, runs the window
  task automatic run_win(input int rises, input string tag);
    exp_t e;
    int dir = 0;
    if (rises + db < tgt) dir = 1;
    else if (rises > tgt + db) dir = 2;
    if (dir == 1 && m_code < cmax) m_code++;
    if (dir == 2 && m_code > cmin) m_code--;
    if (dir == 0 || dir != m_last) m_settle++;
    else m_settle = 0;
    if (dir != 0) m_last = dir;
    e.code = m_code;
    e.lock = (m_settle >= llen) ? 1 : 0;
    e.tag  = tag;
    q.push_back(e);
    repeat (W) @(posedge clk);
    @(negedge clk);
    ->mon_ev;
  endtask

  task automatic enable();
    @(negedge clk);
    en = 1'b1;
    m_settle = 0;
    m_last = 0;
  endtask

  task automatic disable_wait(input int n);
    @(negedge clk);
    en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(code == 8'd128, "R1 reset code", code, 128);
    chk(lock == 1'b0, "R1 reset lock", lock, 0);
    rst_ni = 1'b1;

    // R2: replica runs, loop disabled
    repeat (40) @(negedge clk);
    chk(code == 8'd128, "R2 disabled code", code, 128);
    chk(lock == 1'b0, "R2 disabled lock", lock, 0);

    // 16 rises per window; R3 exact count, R7 hold, R11 lock
    enable();
    run_win(16, "R3 R7 on target");
    run_win(16, "R7 on target");
    run_win(16, "R11 lock reached");
    tgt = 18; run_win(16, "R5 up");
    run_win(16, "R5 R11 repeat up clears lock");
    tgt = 17; run_win(16, "R7 upper bound");
    tgt = 15; run_win(16, "R7 lower bound");
    db = 0; tgt = 17; run_win(16, "R5 R7 zero deadband");
    db = 1; tgt = 20; run_win(16, "R8 max hold");
    run_win(16, "R8 max hold again");
    tgt = 12; run_win(16, "R6 down");
    run_win(16, "R6 down again");
    cmin = 129; run_win(16, "R9 min hold");
    run_win(16, "R9 min hold again");

    disable_wait(30);
    chk(code == 8'(m_code), "R2 hold after disable", code, m_code);
    chk(lock == 1'b0, "R2 lock cleared", lock, 0);

    // R4 prescaler: 16 rises / 2
    div = 2; cmin = 100; tgt = 8; db = 0;
    enable();
    run_win(8, "R4 div2 on target");
    tgt = 9; run_win(8, "R4 div2 up");
    tgt = 7; run_win(8, "R4 div2 down");

    // R3 fastest pattern: 32 rises
    disable_wait(4);
    div = 1; half = 1;
    repeat (20) @(negedge clk);
    tgt = 32; enable();
    run_win(32, "R3 fast on target");
    tgt = 33; run_win(32, "R3 R5 fast up");

    // R12 closed loop
    disable_wait(4);
    rst_ni = 1'b0;
    cl_mode = 1'b1;
    cmin = 100; cmax = 250; tgt = 12; db = 1; llen = 4;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    enable();
    for (int w = 0; w < 300; w++) begin
      repeat (W) @(posedge clk);
      @(negedge clk);
      if (lock) break;
    end
    chk(lock == 1'b1, "R12 closed-loop lock", lock, 1);
    chk(code >= 8'd130 && code <= 8'd170, "R12 code near ideal 150", code, 150);

    summary();
    $finish;
  end
endmodule